// File: doc/BRIEF.md
# Five-Window Stereo Disparity Engine

This block finds, for every pixel on the middle scanline of a stereo strip, the horizontal shift that best aligns the right image with the left image. It first takes in the whole strip one column at a time. Each column carries every strip row of both images. It then sweeps the candidate shifts one after another, and for each shift it walks across the columns once. Finally it streams out one disparity byte per column, together with a flag that says whether the result is meaningful.

The matching cost for a pixel is built from five rectangular windows. The centre window E is centred on the pixel. The four corner windows are A (upper left), B (upper right), C (lower left) and D (lower right), and each of them includes the pixel itself at its corner. Each window score is a sum of absolute differences, formed with running column sums that add the entering column and drop the leaving one. The cost is the E score plus the two smallest corner scores. The left corner scores are not computed separately: they are the right corner scores delayed by WIN_H columns. The output for a pixel is the shift with the lowest cost.

Top module: `msad_disparity`

## Requirements
- R1: The block accepts exactly WIDTH input beats, each completed when `in_valid` and `in_ready` are both high on a clock edge. Beat k carries column k, and strip row r sits at bits [8r+7:8r] of `in_left` and `in_right`. Stalls in `in_valid` do not change the result. `in_ready` stays low from the last beat until the last output has been taken.
- R2: With V = WIN_V and centre pixel (V, x), the windows are as follows. E covers rows V-CEN_V..V+CEN_V and columns x-CEN_H..x+CEN_H. A covers rows 0..V and columns x-WIN_H..x. B covers rows 0..V and columns x..x+WIN_H. C covers rows V..2V and columns x-WIN_H..x. D covers rows V..2V and columns x..x+WIN_H.
- R3: For candidate shift d, a window score is the sum over its pixels of |right(r,c) - left(r,c-d)|. Internal sums never exceed the largest value such a window can reach.
- R4: The cost at shift d is score(E) plus the two smallest of score(A), score(B), score(C) and score(D).
- R5: The output disparity is the d in 0..MAX_D-1 with the lowest cost. When several shifts tie, the smallest d wins.
- R6: A column x is valid only when WIN_H+MAX_D-1 <= x <= WIDTH-1-WIN_H. Every other column is output with `out_disp` = 0 and `out_ok` = 0. Valid columns have `out_ok` = 1.
- R7: Exactly WIDTH output beats follow, in column order 0..WIDTH-1. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_disp` and `out_ok` keep their values.
- R8: After reset, `in_ready` = 1 and `out_valid` = 0. After the last output beat, the block accepts a new strip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input column present |
| in_ready | output | 1 | Block can take an input column |
| in_left | input | (2*WIN_V+1)*8 | Left-image column, row r at bits [8r+7:8r] |
| in_right | input | (2*WIN_V+1)*8 | Right-image column, same layout |
| out_valid | output | 1 | Output disparity present |
| out_ready | input | 1 | Consumer takes the output |
| out_disp | output | 8 | Disparity of the current column |
| out_ok | output | 1 | Column lies inside the valid range |

## Verification
Four things are checked on every clock: output stalls keep the result steady, input and output phases never overlap, invalid columns always carry a zero disparity, and the output never leaves the shift range. Two more hold throughout the sweep: running window sums stay within their bound, and the selected cost never exceeds the centre score plus the smaller of two corner pairs. Only the bench scenarios can show that the chosen disparity is the right one. These scenarios cover a known global shift, flat images where every shift ties, an occluding patch that forces the two-smallest selection, and input gaps combined with output backpressure. Each result is compared against a direct window-by-window model.

// File: rtl/msad_pkg.sv
package msad_pkg;
    localparam int PIX_W = 8;

    typedef enum logic [1:0] {PH_LOAD, PH_SWEEP, PH_EMIT} phase_e;

    function automatic logic [PIX_W-1:0] absdiff(input logic [PIX_W-1:0] a, input logic [PIX_W-1:0] b);
        return (a > b) ? a - b : b - a;
    endfunction
endpackage

// File: rtl/msad_colsum.sv
// Sum of absolute differences over rows R_LO..R_HI of one column pair.
module msad_colsum #(
    parameter int ROWS = 15,
    parameter int R_LO = 0,
    parameter int R_HI = 7,
    parameter int SW   = 17
) (
    input  logic [ROWS*8-1:0] rcol,
    input  logic [ROWS*8-1:0] lcol,
    input  logic              lok,
    output logic [SW-1:0]     sum
);
    import msad_pkg::*;

    always_comb begin
        sum = '0;
        if (lok) begin
            for (int r = R_LO; r <= R_HI; r++) begin
                sum = sum + SW'(absdiff(rcol[r*8 +: 8], lcol[r*8 +: 8]));
            end
        end
    end
endmodule

// File: rtl/msad_boxsum.sv
// Running horizontal window sum of LEN columns, plus the same sum DLY columns ago.
module msad_boxsum #(
    parameter int LEN  = 24,
    parameter int DLY  = 23,
    parameter int SW   = 17,
    parameter int NROW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          first,
    input  logic [SW-1:0] cs,
    output logic [SW-1:0] win_now,
    output logic [SW-1:0] win_dly
);
    localparam longint MAXV = longint'(LEN) * NROW * 255;

    typedef struct packed {
        logic [LEN-1:0][SW-1:0] hist;
        logic [DLY-1:0][SW-1:0] dl;
        logic [SW-1:0]          sum;
    } box_t;

    box_t q, n;

    always_comb begin
        logic [SW-1:0] base, leave;
        n       = q;
        base    = first ? '0 : q.sum;
        leave   = first ? '0 : q.hist[LEN-1];
        win_now = base + cs - leave;
        win_dly = q.dl[DLY-1];
        if (en) begin
            n.sum = win_now;
            for (int k = LEN - 1; k >= 1; k--) n.hist[k] = first ? '0 : q.hist[k-1];
            n.hist[0] = cs;
            for (int j = DLY - 1; j >= 1; j--) n.dl[j] = first ? '0 : q.dl[j-1];
            n.dl[0] = win_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    // R3: the running sum stays inside what a full window can hold
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        longint'(q.sum) <= MAXV);
endmodule

// File: rtl/msad_pick2.sv
// Centre score plus the two smallest of four corner scores.
module msad_pick2 #(
    parameter int SW = 17
) (
    input  logic [SW-1:0] e,
    input  logic [SW-1:0] a,
    input  logic [SW-1:0] b,
    input  logic [SW-1:0] c,
    input  logic [SW-1:0] d,
    output logic [SW-1:0] cost
);
    always_comb begin
        logic [SW-1:0] lo1, hi1, lo2, hi2, m1, m2;
        lo1  = (a < b) ? a : b;
        hi1  = (a < b) ? b : a;
        lo2  = (c < d) ? c : d;
        hi2  = (c < d) ? d : c;
        m1   = (lo1 < lo2) ? lo1 : lo2;
        m2   = (lo1 < lo2) ? ((lo2 < hi1) ? lo2 : hi1) : ((lo1 < hi2) ? lo1 : hi2);
        cost = e + m1 + m2;
    end
endmodule

// File: rtl/msad_disparity.sv
module msad_disparity #(
    parameter int WIDTH = 640,
    parameter int WIN_H = 23,
    parameter int WIN_V = 7,
    parameter int CEN_H = 7,
    parameter int CEN_V = 3,
    parameter int MAX_D = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [(2*WIN_V+1)*8-1:0] in_left,
    input  logic [(2*WIN_V+1)*8-1:0] in_right,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [7:0]               out_disp,
    output logic                     out_ok
);
    import msad_pkg::*;

    localparam int ROWS = 2 * WIN_V + 1;
    localparam int CW   = ROWS * 8;
    localparam int XW   = $clog2(WIDTH);
    localparam int DW   = $clog2(MAX_D);
    localparam int NE   = (2 * CEN_H + 1) * (2 * CEN_V + 1);
    localparam int NC   = (WIN_H + 1) * (WIN_V + 1);
    localparam int SW   = $clog2((NE + 2 * NC) * 255 + 1);
    localparam logic [XW-1:0] X_LO = XW'(WIN_H + MAX_D - 1);
    localparam logic [XW-1:0] X_HI = XW'(WIDTH - 1 - WIN_H);
    localparam logic [XW-1:0] X_WH = XW'(WIN_H);
    localparam logic [XW-1:0] X_LAST = XW'(WIDTH - 1);
    localparam logic [DW-1:0] D_LAST = DW'(MAX_D - 1);
    // stream 0: upper corners, 1: lower corners, 2: centre
    localparam int S_LO[3]  = '{0, WIN_V, WIN_V - CEN_V};
    localparam int S_HI[3]  = '{WIN_V, 2 * WIN_V, WIN_V + CEN_V};
    localparam int S_LEN[3] = '{WIN_H + 1, WIN_H + 1, 2 * CEN_H + 1};
    localparam int S_DLY[3] = '{WIN_H, WIN_H, WIN_H - CEN_H};

    typedef struct packed {
        phase_e        st;
        logic [XW-1:0] c;
        logic [XW-1:0] x;
        logic [DW-1:0] d;
    } ctl_t;

    ctl_t q, n;

    logic [CW-1:0] lmem [WIDTH];
    logic [CW-1:0] rmem [WIDTH];
    logic [SW-1:0] bs   [WIDTH];
    logic [DW-1:0] bd   [WIDTH];

    logic [CW-1:0] rcol, lcol;
    logic          lok, sweep, first, xv, load_we, best_we;
    logic [XW-1:0] x_s;
    logic [SW-1:0] cs  [3];
    logic [SW-1:0] now [3];
    logic [SW-1:0] dly [3];
    logic [SW-1:0] cost;

    function automatic logic col_ok(input logic [XW-1:0] x);
        return (x >= X_LO) && (x <= X_HI);
    endfunction

    assign sweep = (q.st == PH_SWEEP);
    assign first = (q.c == '0);
    assign rcol  = rmem[q.c];
    assign lok   = (q.c >= XW'(q.d));
    assign lcol  = lok ? lmem[q.c - XW'(q.d)] : '0;
    assign x_s   = q.c - X_WH;
    assign xv    = sweep && (q.c >= X_WH) && col_ok(x_s);

    for (genvar s = 0; s < 3; s++) begin : g_stream
        msad_colsum #(.ROWS(ROWS), .R_LO(S_LO[s]), .R_HI(S_HI[s]), .SW(SW)) u_col (
            .rcol(rcol), .lcol(lcol), .lok(lok), .sum(cs[s])
        );
        msad_boxsum #(.LEN(S_LEN[s]), .DLY(S_DLY[s]), .SW(SW), .NROW(S_HI[s] - S_LO[s] + 1)) u_box (
            .clk(clk), .rst_n(rst_n), .en(sweep), .first(first), .cs(cs[s]),
            .win_now(now[s]), .win_dly(dly[s])
        );
    end

    // left corners are the right corners seen WIN_H columns earlier
    msad_pick2 #(.SW(SW)) u_pick (
        .e(dly[2]), .a(dly[0]), .b(now[0]), .c(dly[1]), .d(now[1]), .cost(cost)
    );

    always_comb begin
        n         = q;
        in_ready  = (q.st == PH_LOAD);
        out_valid = (q.st == PH_EMIT);
        out_ok    = out_valid && col_ok(q.x);
        out_disp  = out_ok ? 8'(bd[q.x]) : 8'd0;
        load_we   = in_valid && in_ready;
        best_we   = xv && ((q.d == '0) || (cost < bs[x_s]));
        case (q.st)
            PH_LOAD: if (load_we) begin
                n.c = (q.c == X_LAST) ? '0 : q.c + 1'b1;
                if (q.c == X_LAST) begin
                    n.st = PH_SWEEP;
                    n.d  = '0;
                end
            end
            PH_SWEEP: begin
                n.c = (q.c == X_LAST) ? '0 : q.c + 1'b1;
                if (q.c == X_LAST) begin
                    n.d = q.d + 1'b1;
                    if (q.d == D_LAST) begin
                        n.st = PH_EMIT;
                        n.x  = '0;
                    end
                end
            end
            default: if (out_ready) begin
                n.x = q.x + 1'b1;
                if (q.x == X_LAST) n.st = PH_LOAD;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: PH_LOAD, c: '0, x: '0, d: '0};
        else        q <= n;
    end

    always_ff @(posedge clk) begin
        if (load_we) begin
            lmem[q.c] <= in_left;
            rmem[q.c] <= in_right;
        end
        if (best_we) begin
            bs[x_s] <= cost;
            bd[x_s] <= q.d;
        end
    end

    // R7: a stalled output keeps its beat
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_disp) && $stable(out_ok));
    // R6: columns outside the valid range report zero
    p_edge_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ok |-> out_disp == 8'd0);
    // R5: disparity stays within the candidate range
    p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_disp < 8'(MAX_D));
    // R1: input and output phases never overlap
    p_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));
    // R4: corner part of the cost is no larger than either same-row pair
    p_pick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xv |-> (cost >= dly[2]) &&
               ({1'b0, cost - dly[2]} <= {1'b0, dly[0]} + {1'b0, now[0]}) &&
               ({1'b0, cost - dly[2]} <= {1'b0, dly[1]} + {1'b0, now[1]}));
endmodule

// File: tb/msad_disparity_tb.sv
module msad_disparity_tb;
    localparam int W  = 20;
    localparam int WH = 2;
    localparam int WV = 2;
    localparam int CH = 1;
    localparam int CV = 1;
    localparam int MD = 4;
    localparam int RW = 2 * WV + 1;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_ready, out_valid, out_ready = 0, out_ok;
    logic [RW*8-1:0] in_left = '0, in_right = '0;
    logic [7:0] out_disp;

    int checks = 0, errors = 0;
    int lp [RW][W];
    int rp [RW][W];
    int got_d [W];
    int got_ok [W];
    int unsigned seed = 32'h1234_5678;
    bit done = 0;

    always #4 clk = ~clk;

    msad_disparity #(.WIDTH(W), .WIN_H(WH), .WIN_V(WV), .CEN_H(CH), .CEN_V(CV), .MAX_D(MD)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
        .out_ready(out_ready), .out_disp(out_disp), .out_ok(out_ok)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) & 32'hFF);
    endfunction

    function automatic int wsad(int r0, int r1, int c0, int c1, int d);
        int s = 0;
        for (int r = r0; r <= r1; r++)
            for (int c = c0; c <= c1; c++) begin
                int v = rp[r][c] - lp[r][c - d];
                s += (v < 0) ? -v : v;
            end
        return s;
    endfunction

    function automatic int model_cost(int x, int d);
        int k[4];
        int t;
        k[0] = wsad(0, WV, x - WH, x, d);
        k[1] = wsad(0, WV, x, x + WH, d);
        k[2] = wsad(WV, 2 * WV, x - WH, x, d);
        k[3] = wsad(WV, 2 * WV, x, x + WH, d);
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 3; j++)
                if (k[j] > k[j+1]) begin t = k[j]; k[j] = k[j+1]; k[j+1] = t; end
        return wsad(WV - CV, WV + CV, x - CH, x + CH, d) + k[0] + k[1];
    endfunction

    function automatic bit xvalid(int x);
        return (x >= WH + MD - 1) && (x <= W - 1 - WH);
    endfunction

    function automatic int model_disp(int x);
        int best = model_cost(x, 0), bd = 0;
        for (int d = 1; d < MD; d++)
            if (model_cost(x, d) < best) begin best = model_cost(x, d); bd = d; end
        return bd;
    endfunction

    // drive one strip and collect all outputs; gaps and backpressure optional
    task automatic run_strip(input bit gaps, input bit stall);
        int col = 0, k = 0, got = 0;
        int hold_d = 0, hold_ok = 0;
        bit held = 0;
        while (col < W) begin
            @(negedge clk);
            in_valid = !(gaps && (k % 3 == 1));
            for (int r = 0; r < RW; r++) begin
                in_left[r*8 +: 8]  = 8'(lp[r][col]);
                in_right[r*8 +: 8] = 8'(rp[r][col]);
            end
            if (in_valid && in_ready) col++;
            k++;
        end
        @(negedge clk);
        in_valid = 0;
        chk(!in_ready, "R1 in_ready low after last column", int'(in_ready), 0);
        k = 0;
        while (got < W) begin
            @(negedge clk);
            if (held) begin
                chk(out_valid && int'(out_disp) == hold_d && int'(out_ok) == hold_ok,
                    "R7 stalled beat held", int'(out_disp), hold_d);
                held = 0;
            end
            out_ready = !(stall && (k % 3 == 0));
            if (out_valid && out_ready) begin
                got_d[got] = int'(out_disp);
                got_ok[got] = int'(out_ok);
                got++;
            end else if (out_valid) begin
                held = 1; hold_d = int'(out_disp); hold_ok = int'(out_ok);
            end
            k++;
        end
        @(negedge clk);
        out_ready = 0;
    endtask

    task automatic check_all(input string tag);
        for (int x = 0; x < W; x++) begin
            if (xvalid(x)) begin
                chk(got_ok[x] == 1, "R6 valid column flagged", got_ok[x], 1);
                chk(got_d[x] == model_disp(x), tag, got_d[x], model_disp(x));
            end else begin
                chk(got_ok[x] == 0 && got_d[x] == 0, "R6 edge column zero", got_d[x], 0);
            end
        end
    endtask

    task automatic fill_shift(input int sh);
        for (int r = 0; r < RW; r++)
            for (int c = 0; c < W; c++) lp[r][c] = rnd();
        for (int r = 0; r < RW; r++)
            for (int c = 0; c < W; c++) rp[r][c] = (c >= sh) ? lp[r][c - sh] : rnd();
    endtask

    task automatic t_reset();
        chk(in_ready == 1'b1, "R8 in_ready after reset", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R8 out_valid after reset", int'(out_valid), 0);
    endtask

    task automatic t_shift();
        fill_shift(2);
        run_strip(0, 0);
        check_all("R3 R5 global shift");
        chk(got_d[10] == 2, "R3 known shift recovered", got_d[10], 2);
    endtask

    task automatic t_flat();
        for (int r = 0; r < RW; r++)
            for (int c = 0; c < W; c++) begin lp[r][c] = 100; rp[r][c] = 100; end
        run_strip(0, 0);
        for (int x = WH + MD - 1; x <= W - 1 - WH; x++)
            chk(got_d[x] == 0, "R5 tie picks lowest shift", got_d[x], 0);
    endtask

    task automatic t_corner();
        fill_shift(1);
        for (int r = WV; r < RW; r++)
            for (int c = 11; c < W; c++) rp[r][c] = lp[r][c - 3];
        run_strip(0, 0);
        check_all("R2 R4 occluded corner");
    endtask

    task automatic t_stall();
        fill_shift(3);
        run_strip(1, 1);
        check_all("R1 R7 gaps and backpressure");
    endtask

    task automatic t_again();
        chk(in_ready == 1'b1, "R8 ready for next strip", int'(in_ready), 1);
        fill_shift(0);
        run_strip(0, 1);
        check_all("R8 second strip");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_shift();
        t_flat();
        t_corner();
        t_stall();
        t_again();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule